// File: doc/BRIEF.md
# Multi-mode serial receiver

This block is the receive half of a configurable serial port. It turns a single serial data line back into parallel words. The same mode and framing settings that drive the matching transmitter select how it works. In asynchronous (UART) mode it hunts for a start bit on an idle-high line. It takes each bit by a three-sample majority vote near the middle of the bit. It collects 7, 8 or 9 data bits, optionally checks a parity bit, and checks one or two stop bits. In clock-synchronous mode it takes one data bit on each active edge of an external transfer clock and assembles 8-bit words.

A completed word is held in an output register together with its parity-error and framing-error flags. A valid flag stays set until the consumer pulses a read strobe. If another word completes while the valid flag is still set, an overrun flag rises and the newer word replaces the older one. The bit order (first bit is the least or the most significant) applies in both modes. Both serial inputs pass through two-stage synchronisers. The sample rate is a parameter: `OVS` samples per bit, one sample every `CLKS_PER_SAMPLE` clocks.

Top module: `mmser_rx`

## Requirements
- R1: `cfg_mode` selects the operation. 001 is clock-synchronous. 100, 101 and 110 are UART with 7, 8 and 9 data bits. 000 and every other code disable the receiver, and no word is stored while it is disabled.
- R2: In UART mode `rx_data` holds the received data bits in its low 7, 8 or 9 bits, and every bit above the data length reads 0.
- R3: With `cfg_msb_first`=0 the first data bit on the line lands in `rx_data[0]`. With `cfg_msb_first`=1 it lands in the top bit of the word (bit 6, 7 or 8 in UART mode, bit 7 in synchronous mode).
- R4: With `cfg_par_en`=1 one parity bit follows the data. `cfg_par_even`=1 means the count of ones over data and parity must be even, and `cfg_par_even`=0 means it must be odd. A mismatch sets `rx_perr` with the word. With parity disabled `rx_perr` is 0.
- R5: `cfg_two_stop` selects one (0) or two (1) stop bits. A low level at any expected stop bit sets `rx_ferr` with the word. After such an error the receiver waits for the line to return high before it hunts for a new start bit.
- R6: A falling edge is accepted as a start bit only if the vote at the middle of the start bit is low. Otherwise the receiver returns to idle and stores nothing.
- R7: Each UART bit is decided by a majority of three consecutive samples at mid-bit, so a disturbance one sample long does not change the received value.
- R8: In synchronous mode a bit is taken on the rising edge of `sclk_in` when `cfg_clk_pol`=0 and on the falling edge when `cfg_clk_pol`=1. Every 8 bits form one word, and both error flags are 0.
- R9: `rx_valid` rises when a word is stored. A one-cycle `rd_ack` with no word completing in that cycle clears it.
- R10: If a word completes while `rx_valid` is set and `rd_ack` is low, `rx_ovr` sets and the new word replaces the held one. `rd_ack` clears `rx_ovr`.
- R11: After reset `rx_valid`, `rx_ovr`, `rx_perr`, `rx_ferr` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Operating mode code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_clk_pol | input | 1 | Synchronous sampling edge: 0 rising, 1 falling |
| cfg_msb_first | input | 1 | 1 = first bit on the line is the most significant |
| rxd_in | input | 1 | Serial data line (asynchronous) |
| sclk_in | input | 1 | External transfer clock for synchronous mode (asynchronous) |
| rd_ack | input | 1 | Read strobe, clears valid and overrun |
| rx_data | output | 9 | Received word |
| rx_valid | output | 1 | A word is held |
| rx_perr | output | 1 | Parity error of the held word |
| rx_ferr | output | 1 | Framing error of the held word |
| rx_ovr | output | 1 | A word was replaced before it was read |

## Verification
The UART path is swept over every data length, every parity setting, both stop lengths and both bit orders, using an all-zero, an all-ones and a mixed word. The all-zero and all-ones words expose stuck or misplaced bits, the mixed word tells the two bit orders apart, and the parity sweep tells odd from even. Frames with a flipped parity bit, or with a low first or second stop bit, show that each error flag is raised by its own cause, and a clean frame after a stop error shows recovery. A short low pulse on the idle line, a one-sample glitch moved across every data bit, disabled and reserved mode codes, back-to-back unread words and synchronous words under both clock polarities and bit orders cover start validation, voting, mode decode, overrun and the sampling edge.

// File: rtl/mmser_rx_pkg.sv
// Shared types and helpers for the multi-mode serial receiver.
// Assumes a word never exceeds 9 bits.
package mmser_rx_pkg;

    localparam int WORD_W = 9;

    typedef enum logic [2:0] {
        U_IDLE,
        U_START,
        U_DATA,
        U_PAR,
        U_STOP,
        U_WAITHI
    } ustate_t;

    // Majority of three samples.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Bit position in the word for the idx-th received bit of an n-bit word.
    function automatic logic [3:0] bit_pos(input logic [3:0] idx, input logic [3:0] n,
                                           input logic msb);
        return msb ? (n - 4'd1 - idx) : idx;
    endfunction

endpackage

// File: rtl/mmser_rx_sync.sv
// Two-stage synchroniser for asynchronous inputs.
// Assumes each input is a level that is stable for several clocks.
module mmser_rx_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    // Two flops in series, reset to the line's idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= RST_VAL;
            q  <= RST_VAL;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/mmser_rx_uart.sv
// Asynchronous frame receiver: start hunt, three-sample majority, data, parity and stop.
// Assumes rxd_s is already synchronised and the configuration is stable within a frame.
// Emits a one-cycle st_valid with the word and its error flags at mid of the last stop bit.
module mmser_rx_uart
    import mmser_rx_pkg::*;
#(
    parameter int OVS = 8,
    parameter int CPS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rxd_s,
    input  logic [3:0]        nbits,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              two_stop,
    input  logic              msb_first,
    output logic              st_valid,
    output logic [WORD_W-1:0] st_data,
    output logic              st_perr,
    output logic              st_ferr
);
    localparam int SCW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int MID = OVS / 2;

    logic              tick;
    ustate_t           st;
    logic [SCW-1:0]    scnt;
    logic              v0, v1;
    logic [3:0]        bidx;
    logic              stop2;
    logic [WORD_W-1:0] sh;
    logic              perr, ferr;
    logic              bitv;

    // Sample tick prescaler; a divider only when more than one clock per sample.
    if (CPS <= 1) begin : g_tick_every
        assign tick = 1'b1;
    end else begin : g_tick_div
        localparam int PW = $clog2(CPS);
        logic [PW-1:0] pcnt;

        // Free-running sample divider, held at zero while disabled.
        always_ff @(posedge clk) begin
            if (!rst_n || !en)                pcnt <= '0;
            else if (pcnt == PW'(CPS - 1))    pcnt <= '0;
            else                              pcnt <= pcnt + 1'b1;
        end
        assign tick = (pcnt == PW'(CPS - 1));
    end

    assign bitv = maj3(v0, v1, rxd_s);

    // Frame sequencer with per-bit sample counter and word assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= U_IDLE;
            scnt     <= '0;
            v0       <= 1'b1;
            v1       <= 1'b1;
            bidx     <= '0;
            stop2    <= 1'b0;
            sh       <= '0;
            perr     <= 1'b0;
            ferr     <= 1'b0;
            st_valid <= 1'b0;
            st_data  <= '0;
            st_perr  <= 1'b0;
            st_ferr  <= 1'b0;
        end else begin
            st_valid <= 1'b0;
            if (!en) begin
                st <= U_IDLE;
            end else if (tick) begin
                case (st)
                    U_IDLE: begin
                        if (!rxd_s) begin
                            st    <= U_START;
                            scnt  <= SCW'(1);
                            sh    <= '0;
                            perr  <= 1'b0;
                            ferr  <= 1'b0;
                            stop2 <= 1'b0;
                            bidx  <= '0;
                        end
                    end
                    U_WAITHI: begin
                        if (rxd_s) st <= U_IDLE;
                    end
                    U_START, U_DATA, U_PAR, U_STOP: begin
                        scnt <= (scnt == SCW'(OVS - 1)) ? '0 : scnt + 1'b1;
                        if (scnt == SCW'(MID - 1)) v0 <= rxd_s;
                        if (scnt == SCW'(MID))     v1 <= rxd_s;
                        if (scnt == SCW'(MID + 1)) begin
                            case (st)
                                U_START: st <= bitv ? U_IDLE : U_DATA;
                                U_DATA: begin
                                    sh[bit_pos(bidx, nbits, msb_first)] <= bitv;
                                    bidx <= bidx + 4'd1;
                                    if (bidx == nbits - 4'd1)
                                        st <= par_en ? U_PAR : U_STOP;
                                end
                                U_PAR: begin
                                    perr <= (^sh) ^ bitv ^ ~par_even;
                                    st   <= U_STOP;
                                end
                                U_STOP: begin
                                    if (two_stop && !stop2) begin
                                        stop2 <= 1'b1;
                                        ferr  <= ferr | ~bitv;
                                    end else begin
                                        st_valid <= 1'b1;
                                        st_data  <= sh;
                                        st_perr  <= perr;
                                        st_ferr  <= ferr | ~bitv;
                                        st       <= (ferr | ~bitv) ? U_WAITHI : U_IDLE;
                                    end
                                end
                                default: st <= U_IDLE;
                            endcase
                        end
                    end
                    default: st <= U_IDLE;
                endcase
            end
        end
    end

    // R1
    uart_store_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $past(en));

    // R5
    uart_store_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $past(st) == U_STOP);

    // R5
    uart_ferr_waits_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ferr) |-> st == U_WAITHI);

    // R4
    uart_noparity_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !$past(par_en)) |-> !st_perr);
endmodule

// File: rtl/mmser_rx_clkd.sv
// Clock-synchronous deserialiser: one bit per selected transfer-clock edge.
// Assumes sclk_s and rxd_s are synchronised and the transfer clock is much slower than clk.
module mmser_rx_clkd
    import mmser_rx_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sclk_s,
    input  logic              rxd_s,
    input  logic              pol,
    input  logic              msb_first,
    output logic              st_valid,
    output logic [WORD_W-1:0] st_data
);
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic              sclk_q;
    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] nxt;
    logic              smp_edge;

    assign smp_edge = en && (pol ? (sclk_q & ~sclk_s) : (~sclk_q & sclk_s));

    // Word with the current line bit placed at its position.
    always_comb begin
        nxt = sh;
        nxt[bit_pos(4'(idx), 4'(NB), msb_first)] = rxd_s;
    end

    // Edge tracking, bit counting and word hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b1;
            idx      <= '0;
            sh       <= '0;
            st_valid <= 1'b0;
            st_data  <= '0;
        end else begin
            sclk_q   <= sclk_s;
            st_valid <= 1'b0;
            if (!en) begin
                idx <= '0;
                sh  <= '0;
            end else if (smp_edge) begin
                if (idx == IW'(NB - 1)) begin
                    idx      <= '0;
                    sh       <= '0;
                    st_valid <= 1'b1;
                    st_data  <= nxt;
                end else begin
                    idx <= idx + 1'b1;
                    sh  <= nxt;
                end
            end
        end
    end

    // R8
    clkd_store_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $past(smp_edge));
endmodule

// File: rtl/mmser_rx_hold.sv
// Output holding register with valid and overrun tracking.
// Assumes store is a one-cycle pulse; a store in the same cycle as rd_ack wins.
module mmser_rx_hold
    import mmser_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_perr,
    input  logic              in_ferr,
    input  logic              rd_ack,
    output logic [WORD_W-1:0] data,
    output logic              perr,
    output logic              ferr,
    output logic              valid,
    output logic              ovr
);
    // Capture a completed word or clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            valid <= 1'b0;
            ovr   <= 1'b0;
        end else if (store) begin
            data  <= in_data;
            perr  <= in_perr;
            ferr  <= in_ferr;
            valid <= 1'b1;
            ovr   <= valid && !rd_ack;
        end else if (rd_ack) begin
            valid <= 1'b0;
            ovr   <= 1'b0;
        end
    end

    // R10
    ovr_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> valid);

    // R10
    ovr_on_unread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store && valid && !rd_ack) |=> ovr);

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !store) |=> (!valid && !ovr));

    // R9
    store_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> valid);
endmodule

// File: rtl/mmser_rx.sv
// Multi-mode serial receiver top: mode decode, input synchronisers, the two
// receive engines and the shared holding register.
// Assumes configuration changes only while no frame is in flight.
module mmser_rx
    import mmser_rx_pkg::*;
#(
    parameter int OVS             = 8,
    parameter int CLKS_PER_SAMPLE = 2,
    parameter int SYNC_BITS       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_two_stop,
    input  logic              cfg_clk_pol,
    input  logic              cfg_msb_first,
    input  logic              rxd_in,
    input  logic              sclk_in,
    input  logic              rd_ack,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_ovr
);
    logic              uart_en, clkd_en;
    logic [3:0]        nbits;
    logic [1:0]        sync_q;
    logic              rxd_s, sclk_s;
    logic              u_valid, c_valid;
    logic [WORD_W-1:0] u_data, c_data;
    logic              u_perr, u_ferr;
    logic              store;
    logic [WORD_W-1:0] sel_data;

    // Mode decode: only the listed codes enable an engine.
    always_comb begin
        uart_en = (cfg_mode == 3'b100) || (cfg_mode == 3'b101) || (cfg_mode == 3'b110);
        clkd_en = (cfg_mode == 3'b001);
        nbits   = 4'd7 + {2'b00, cfg_mode[1:0]};
    end

    mmser_rx_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, rxd_in}),
        .q     (sync_q)
    );
    assign sclk_s = sync_q[1];
    assign rxd_s  = sync_q[0];

    mmser_rx_uart #(.OVS(OVS), .CPS(CLKS_PER_SAMPLE)) u_uart (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (uart_en),
        .rxd_s     (rxd_s),
        .nbits     (nbits),
        .par_en    (cfg_par_en),
        .par_even  (cfg_par_even),
        .two_stop  (cfg_two_stop),
        .msb_first (cfg_msb_first),
        .st_valid  (u_valid),
        .st_data   (u_data),
        .st_perr   (u_perr),
        .st_ferr   (u_ferr)
    );

    mmser_rx_clkd #(.NB(SYNC_BITS)) u_clkd (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (clkd_en),
        .sclk_s    (sclk_s),
        .rxd_s     (rxd_s),
        .pol       (cfg_clk_pol),
        .msb_first (cfg_msb_first),
        .st_valid  (c_valid),
        .st_data   (c_data)
    );

    // Select the engine that completed a word.
    always_comb begin
        store    = u_valid | c_valid;
        sel_data = c_valid ? c_data : u_data;
    end

    mmser_rx_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .store   (store),
        .in_data (sel_data),
        .in_perr (u_valid & u_perr),
        .in_ferr (u_valid & u_ferr),
        .rd_ack  (rd_ack),
        .data    (rx_data),
        .perr    (rx_perr),
        .ferr    (rx_ferr),
        .valid   (rx_valid),
        .ovr     (rx_ovr)
    );

    // R1
    one_engine_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({u_valid, c_valid}));

    // R8
    clkd_word_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_valid |=> (rx_valid && !rx_perr && !rx_ferr));
endmodule

// File: tb/mmser_rx_tb_top.sv
// Self-checking bench: frames are built bit by bit from the requirements.
module mmser_rx_tb_top;
    localparam int OVS = 8;
    localparam int CPS = 2;
    localparam int BIT = OVS * CPS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'b000;
    logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0;
    logic       cfg_clk_pol = 1'b0, cfg_msb_first = 1'b0;
    logic       rxd_in = 1'b1, sclk_in = 1'b1, rd_ack = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr, rx_ovr;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    mmser_rx #(.OVS(OVS), .CLKS_PER_SAMPLE(CPS), .SYNC_BITS(8)) dut_i (
        .clk, .rst_n, .cfg_mode, .cfg_par_en, .cfg_par_even, .cfg_two_stop,
        .cfg_clk_pol, .cfg_msb_first, .rxd_in, .sclk_in, .rd_ack,
        .rx_data, .rx_valid, .rx_perr, .rx_ferr, .rx_ovr
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] m, input int pm, input bit two, input bit pol, input bit msb);
        @(negedge clk);
        cfg_mode      = m;
        cfg_par_en    = (pm != 0);
        cfg_par_even  = (pm == 2);
        cfg_two_stop  = two;
        cfg_clk_pol   = pol;
        cfg_msb_first = msb;
        idle(4);
    endtask

    // One bit period; g flips the line for one sample time near mid-bit.
    task automatic drive_bit(input logic b, input bit g);
        for (int c = 0; c < BIT; c++) begin
            @(negedge clk);
            rxd_in = (g && (c == 9 || c == 10)) ? ~b : b;
        end
    endtask

    // pm: 0 none, 1 odd, 2 even. glitch_bit selects a data bit to disturb (-1 none).
    task automatic send_uart(input logic [8:0] v, input int nb, input int pm, input bit two,
                             input bit msb, input bit bad_par, input bit bad_s1,
                             input bit bad_s2, input int glitch_bit);
        logic ones;
        logic pb;
        ones = 1'b0;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < nb; i++) begin
            ones ^= v[i];
            drive_bit(msb ? v[nb-1-i] : v[i], glitch_bit == i);
        end
        if (pm != 0) begin
            pb = (pm == 2) ? ones : ~ones;
            drive_bit(pb ^ bad_par, 1'b0);
        end
        drive_bit(~bad_s1, 1'b0);
        if (two) drive_bit(~bad_s2, 1'b0);
        @(negedge clk) rxd_in = 1'b1;
    endtask

    // Synchronous word; data changes away from the sampling edge.
    task automatic send_clkd(input logic [7:0] v, input bit pol, input bit msb);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) sclk_in = pol;
            idle(4);
            rxd_in = msb ? v[7-i] : v[i];
            idle(4);
            sclk_in = ~pol;
            idle(8);
        end
    endtask

    task automatic check_word(input logic [8:0] exp, input logic pe, input logic fe, input string tag);
        chk(rx_valid == 1'b1, {tag, " R9 valid"}, rx_valid, 1);
        chk(rx_data == exp, {tag, " R2/R3 data"}, rx_data, exp);
        chk(rx_perr == pe, {tag, " R4 perr"}, rx_perr, pe);
        chk(rx_ferr == fe, {tag, " R5 ferr"}, rx_ferr, fe);
        chk(rx_ovr == 1'b0, {tag, " R10 ovr"}, rx_ovr, 0);
        ack();
        chk(rx_valid == 1'b0, {tag, " R9 cleared"}, rx_valid, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [8:0] mask;
        logic [8:0] v;
        idle(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(rx_valid == 0 && rx_ovr == 0, "R11 flags", {rx_valid, rx_ovr}, 0);
        chk(rx_perr == 0 && rx_ferr == 0, "R11 errors", {rx_perr, rx_ferr}, 0);
        chk(rx_data == 0, "R11 data", rx_data, 0);

        // R2 R3 R4 R5 sweep over all UART framings
        for (int nbsel = 0; nbsel < 3; nbsel++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int two = 0; two < 2; two++) begin
                    for (int msb = 0; msb < 2; msb++) begin
                        set_cfg(3'(4 + nbsel), pm, two[0], 1'b0, msb[0]);
                        mask = 9'((1 << (7 + nbsel)) - 1);
                        for (int k = 0; k < 3; k++) begin
                            v = (k == 0) ? 9'h000 : (k == 1) ? mask :
                                (9'h12B ^ 9'(nbsel * 77 + pm * 31 + two * 13 + msb * 7)) & mask;
                            send_uart(v, 7 + nbsel, pm, two[0], msb[0], 0, 0, 0, -1);
                            idle(BIT);
                            check_word(v, 1'b0, 1'b0, "sweep");
                        end
                    end
                end
            end
        end

        // R4 parity errors, both types, shortest and longest words
        set_cfg(3'b100, 2, 1'b0, 1'b0, 1'b0);
        send_uart(9'h035, 7, 2, 0, 0, 1, 0, 0, -1); idle(BIT);
        check_word(9'h035, 1'b1, 1'b0, "R4 even bad");
        set_cfg(3'b110, 1, 1'b1, 1'b0, 1'b1);
        send_uart(9'h1C3, 9, 1, 1, 1, 1, 0, 0, -1); idle(BIT);
        check_word(9'h1C3, 1'b1, 1'b0, "R4 odd bad");

        // R5 stop errors: first and second of two, and the only one
        set_cfg(3'b101, 0, 1'b1, 1'b0, 1'b0);
        send_uart(9'h0A7, 8, 0, 1, 0, 0, 1, 0, -1); idle(2 * BIT);
        check_word(9'h0A7, 1'b0, 1'b1, "R5 stop1 low");
        send_uart(9'h05C, 8, 0, 1, 0, 0, 0, 1, -1); idle(2 * BIT);
        check_word(9'h05C, 1'b0, 1'b1, "R5 stop2 low");
        set_cfg(3'b101, 1, 1'b0, 1'b0, 1'b0);
        send_uart(9'h0F0, 8, 1, 0, 0, 0, 1, 0, -1); idle(2 * BIT);
        check_word(9'h0F0, 1'b0, 1'b1, "R5 single stop low");
        send_uart(9'h00F, 8, 1, 0, 0, 0, 0, 0, -1); idle(BIT);
        check_word(9'h00F, 1'b0, 1'b0, "R5 recovery");

        // R6 short low pulse on an idle line is not a start bit
        set_cfg(3'b101, 0, 1'b0, 1'b0, 1'b0);
        @(negedge clk) rxd_in = 1'b0;
        idle(2);
        rxd_in = 1'b1;
        idle(16 * BIT);
        chk(rx_valid == 1'b0, "R6 false start", rx_valid, 0);
        send_uart(9'h0C9, 8, 0, 0, 0, 0, 0, 0, -1); idle(BIT);
        check_word(9'h0C9, 1'b0, 1'b0, "R6 after false start");

        // R7 one-sample glitch on each data bit in turn
        for (int g = 0; g < 8; g++) begin
            send_uart(9'h0A5, 8, 0, 0, 0, 0, 0, 0, g); idle(BIT);
            check_word(9'h0A5, 1'b0, 1'b0, "R7 glitch");
        end

        // R10 two unread words
        send_uart(9'h011, 8, 0, 0, 0, 0, 0, 0, -1); idle(BIT);
        send_uart(9'h0EE, 8, 0, 0, 0, 0, 0, 0, -1); idle(BIT);
        chk(rx_valid && rx_ovr, "R10 ovr set", {rx_valid, rx_ovr}, 3);
        chk(rx_data == 9'h0EE, "R10 newer word kept", rx_data, 9'h0EE);
        ack();
        chk(!rx_valid && !rx_ovr, "R10 ovr cleared", {rx_valid, rx_ovr}, 0);

        // R1 disabled and reserved codes store nothing
        set_cfg(3'b000, 0, 1'b0, 1'b0, 1'b0);
        send_uart(9'h055, 8, 0, 0, 0, 0, 0, 0, -1); idle(BIT);
        chk(rx_valid == 1'b0, "R1 mode 000", rx_valid, 0);
        set_cfg(3'b011, 0, 1'b0, 1'b0, 1'b0);
        send_uart(9'h055, 8, 0, 0, 0, 0, 0, 0, -1); idle(BIT);
        chk(rx_valid == 1'b0, "R1 mode 011", rx_valid, 0);
        set_cfg(3'b111, 0, 1'b0, 1'b0, 1'b0);
        send_uart(9'h055, 8, 0, 0, 0, 0, 0, 0, -1); idle(BIT);
        chk(rx_valid == 1'b0, "R1 mode 111", rx_valid, 0);

        // R8 synchronous words, both edges and both orders
        for (int pol = 0; pol < 2; pol++) begin
            for (int msb = 0; msb < 2; msb++) begin
                set_cfg(3'b000, 0, 1'b0, pol[0], msb[0]);
                sclk_in = ~pol[0];
                idle(6);
                set_cfg(3'b001, 0, 1'b0, pol[0], msb[0]);
                for (int k = 0; k < 4; k++) begin
                    v = {1'b0, 8'(8'h3C ^ (k * 8'h51) ^ (pol * 8'h0F) ^ (msb * 8'h80))};
                    send_clkd(v[7:0], pol[0], msb[0]);
                    check_word(v, 1'b0, 1'b0, "R8 sync");
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule